// File: doc/BRIEF.md
# Masked Sticky Interrupt Status Register

This block holds a word of sticky event flags. Hardware sources raise the flags: overflow and range checks, modulator overload detectors, a watchdog, a supply monitor and a command decoder. A mask register of the same layout selects which flags may drive one interrupt output. Both registers sit behind a small register bus with one address bit. A status read also returns a fixed 4-bit revision identifier.

Most flags are sticky. Writing a one clears a flag and writing a zero leaves it alone. Three bits behave differently. The command-valid bit is active low: it idles at 1, drops when an invalid command arrives, and only a port initialization or a reset brings it back. The supply-low bit has hysteresis and cannot be cleared until the monitor reports recovery. The revision field is read-only.

Top module: `irq_flag_bank`

## Requirements
- R1: After reset the mask reads 0, every sticky flag reads 0, the command-valid bit reads 1 and `irq_o` is 0. With default parameters a status read then returns 17'h15000.
- R2: A high bit of `evt_i[k]` sets status bit k (bits 10:0) at the next clock edge. The bits are: 0 math overflow, 1 current range, 2 voltage range, 3 power range, 4 RMS current range, 5 RMS voltage range, 6 energy range, 7 pulse accumulator range, 8 watchdog, 9 voltage overload, 10 current overload.
- R3: A status write (`bus_addr_i`=0) with a one in bit k, for k in 10:0, clears that flag. A zero leaves the flag unchanged. If an event and a clear of the same bit happen in the same cycle, the flag stays set.
- R4: A flag whose source is still active (for example a persisting overload) reads set again after a clear.
- R5: A mask write (`bus_addr_i`=1) stores bits 12:0. A mask read returns those bits, with bits 16:13 reading 0.
- R6: `irq_o` is 1 exactly when some active status bit has its mask bit set. Bits 10:0 and 11 count as active when they are 1. Bit 12 counts as active when it is 0. With a zero mask, `irq_o` is 0.
- R7: Status bit 12 (command valid) drops to 0 on `bad_cmd_i` and returns to 1 only on `port_init_i` or reset. If both arrive in the same cycle, the drop wins. Status writes never change this bit.
- R8: `supply_below_low_i` sets status bit 11 and latches a low-supply state. `supply_above_high_i` releases that state. While the state is latched, a write of one to bit 11 has no effect. Once the state is released, the write clears the bit.
- R9: Status bits 16:13 always read `REV_ID` (default 4'hA), and writes do not change them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 1 | 0 selects status, 1 selects mask |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 17 | Write data |
| bus_rdata_o | output | 17 | Read data for the selected register |
| evt_i | input | 11 | Event sources for sticky bits 10:0 |
| bad_cmd_i | input | 1 | Invalid command strobe |
| port_init_i | input | 1 | Port initialization strobe |
| supply_below_low_i | input | 1 | Supply fell below the low threshold |
| supply_above_high_i | input | 1 | Supply rose above the high threshold |
| irq_o | output | 1 | Interrupt request |

## Verification
The bound checker watches several rules on every cycle:
- Any event forces its flag on the following cycle.
- A sticky flag falls only after a matching write of one.
- The supply-low bit falls only while the low state is released.
- The command-valid bit moves only on its two strobes, and a status write never disturbs it.
- A zero mask never raises the interrupt.
- The revision field is stable on status reads.

Only the bench scenarios show the following:
- The exact read values after sequences.
- Set-wins arbitration under a clear.
- Mask read-back with its zero upper field.
- The full hysteresis sequence, in which the supply-low bit survives a clear, then survives recovery until a later clear removes it.

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int N_EVT = 11,
  parameter logic [3:0] REV_ID = 4'hA,
  localparam int W = N_EVT + 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         bus_addr_i,
  input  logic         bus_wr_i,
  input  logic [W-1:0] bus_wdata_i,
  output logic [W-1:0] bus_rdata_o,
  input  logic [N_EVT-1:0] evt_i,
  input  logic         bad_cmd_i,
  input  logic         port_init_i,
  input  logic         supply_below_low_i,
  input  logic         supply_above_high_i,
  output logic         irq_o
);
  localparam int SUP = N_EVT;
  localparam int CMD = N_EVT + 1;
  localparam int MW  = N_EVT + 2;

  logic [N_EVT-1:0] evt_q;
  logic             supply_q;
  logic             latch_q;
  logic             cmd_ok_q;
  logic [MW-1:0]    mask_q;
  logic             wr_stat;
  logic [MW-1:0]    active;

  assign wr_stat = bus_wr_i & ~bus_addr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q    <= '0;
      supply_q <= 1'b0;
      latch_q  <= 1'b0;
      cmd_ok_q <= 1'b1;
      mask_q   <= '0;
    end else begin
      evt_q    <= evt_i | (evt_q & ~(wr_stat ? bus_wdata_i[N_EVT-1:0] : '0));
      supply_q <= supply_below_low_i |
                  (supply_q & ~(wr_stat & bus_wdata_i[SUP] & ~latch_q));
      if (supply_below_low_i)       latch_q <= 1'b1;
      else if (supply_above_high_i) latch_q <= 1'b0;
      if (bad_cmd_i)        cmd_ok_q <= 1'b0;
      else if (port_init_i) cmd_ok_q <= 1'b1;
      if (bus_wr_i & bus_addr_i) mask_q <= bus_wdata_i[MW-1:0];
    end
  end

  assign active      = {~cmd_ok_q, supply_q, evt_q};
  assign irq_o       = |(active & mask_q);
  assign bus_rdata_o = bus_addr_i ? {{(W-MW){1'b0}}, mask_q}
                                  : {REV_ID, cmd_ok_q, supply_q, evt_q};
endmodule

module flag_bank_chk #(
  parameter int N_EVT = 11,
  parameter logic [3:0] REV_ID = 4'hA,
  localparam int W = N_EVT + 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bus_addr_i,
  input logic             bus_wr_i,
  input logic [W-1:0]     bus_wdata_i,
  input logic [W-1:0]     bus_rdata_o,
  input logic [N_EVT-1:0] evt_i,
  input logic             bad_cmd_i,
  input logic             port_init_i,
  input logic             irq_o,
  input logic [N_EVT-1:0] evt_q,
  input logic             supply_q,
  input logic             latch_q,
  input logic             cmd_ok_q,
  input logic [N_EVT+1:0] mask_q
);
  localparam int SUP = N_EVT;
  localparam int CMD = N_EVT + 1;

  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) past_ok <= 1'b0; else past_ok <= 1'b1;

  logic [N_EVT-1:0] clr_view;
  logic             wr_hi;
  assign clr_view = (bus_wr_i && !bus_addr_i) ? bus_wdata_i[N_EVT-1:0] : '0;
  assign wr_hi    = bus_wr_i && !bus_addr_i && (|bus_wdata_i[W-1:SUP]);

  assert_evt_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> (($past(evt_i) & ~evt_q) == '0));

  assert_fall_needs_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> (($past(evt_q) & ~evt_q & ~$past(clr_view)) == '0));

  assert_zero_mask_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |-> !irq_o);

  assert_cmd_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $fell(cmd_ok_q)) |-> $past(bad_cmd_i));

  assert_cmd_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $rose(cmd_ok_q)) |-> $past(port_init_i));

  assert_cmd_ignores_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(wr_hi) && !$past(bad_cmd_i) && !$past(port_init_i)) |-> $stable(cmd_ok_q));

  assert_supply_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $fell(supply_q)) |-> ($past(!latch_q) && $past(bus_wdata_i[SUP])));

  assert_rev_field_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_addr_i |-> (bus_rdata_o[W-1 -: 4] == REV_ID));
endmodule

bind irq_flag_bank flag_bank_chk #(.N_EVT(N_EVT), .REV_ID(REV_ID)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_addr_i(bus_addr_i), .bus_wr_i(bus_wr_i),
  .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .evt_i(evt_i),
  .bad_cmd_i(bad_cmd_i), .port_init_i(port_init_i), .irq_o(irq_o),
  .evt_q(evt_q), .supply_q(supply_q), .latch_q(latch_q), .cmd_ok_q(cmd_ok_q),
  .mask_q(mask_q)
);

// File: tb/irq_flag_bank_tb.sv
`timescale 1ns/1ps
module irq_flag_bank_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_addr_i = 1'b0;
  logic        bus_wr_i = 1'b0;
  logic [16:0] bus_wdata_i = '0;
  logic [16:0] bus_rdata_o;
  logic [10:0] evt_i = '0;
  logic        bad_cmd_i = 1'b0;
  logic        port_init_i = 1'b0;
  logic        below = 1'b0;
  logic        above = 1'b0;
  logic        irq_o;
  int checks = 0;
  int errors = 0;

  always #4 clk_i = ~clk_i;

  irq_flag_bank u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_addr_i(bus_addr_i), .bus_wr_i(bus_wr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .evt_i(evt_i),
    .bad_cmd_i(bad_cmd_i), .port_init_i(port_init_i),
    .supply_below_low_i(below), .supply_above_high_i(above), .irq_o(irq_o)
  );

  // {evt[10:0], wr, addr, wdata[16:0], exp_status[16:0], exp_irq}
  localparam int NV = 10;
  localparam logic [47:0] VEC [NV] = '{
    {11'h001, 1'b0, 1'b0, 17'h00000, 17'h15001, 1'b0},  // R2 math flag
    {11'h000, 1'b1, 1'b1, 17'h00001, 17'h15001, 1'b1},  // R6 mask on bit0
    {11'h000, 1'b1, 1'b0, 17'h00001, 17'h15000, 1'b0},  // R3 clear
    {11'h028, 1'b0, 1'b0, 17'h00000, 17'h15028, 1'b0},  // R2 two flags, masked out
    {11'h000, 1'b1, 1'b0, 17'h00008, 17'h15020, 1'b0},  // R3 clear one
    {11'h002, 1'b1, 1'b0, 17'h00002, 17'h15022, 1'b0},  // R3 set wins
    {11'h000, 1'b1, 1'b0, 17'h1F0FF, 17'h15000, 1'b0},  // R9 R7 upper writes ignored
    {11'h400, 1'b1, 1'b1, 17'h00400, 17'h15400, 1'b1},  // R6 overload masked in
    {11'h400, 1'b1, 1'b0, 17'h00400, 17'h15400, 1'b1},  // R4 persists under clear
    {11'h000, 1'b1, 1'b0, 17'h00400, 17'h15000, 1'b0}   // R4 gone once cleared
  };

  task automatic chk(input string req, input logic [16:0] act, input logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [10:0] ev, input logic wr, input logic ad,
                      input logic [16:0] wd, input logic bc, input logic pi,
                      input logic bl, input logic ah);
    @(negedge clk_i);
    evt_i = ev; bus_wr_i = wr; bus_addr_i = ad; bus_wdata_i = wd;
    bad_cmd_i = bc; port_init_i = pi; below = bl; above = ah;
    @(negedge clk_i);
    evt_i = '0; bus_wr_i = 1'b0; bus_addr_i = 1'b0; bus_wdata_i = '0;
    bad_cmd_i = 1'b0; port_init_i = 1'b0; below = 1'b0; above = 1'b0;
    #1;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    chk("R1 status", bus_rdata_o, 17'h15000);
    chk("R1 irq", {16'h0, irq_o}, 17'h0);
    bus_addr_i = 1'b1; #1;
    chk("R1 mask", bus_rdata_o, 17'h0);
    bus_addr_i = 1'b0; #1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][47:37], VEC[i][36], VEC[i][35], VEC[i][34:18], 1'b0, 1'b0, 1'b0, 1'b0);
      chk($sformatf("R2/R3/R4/R6 vec%0d status", i), bus_rdata_o, VEC[i][17:1]);
      chk($sformatf("R6 vec%0d irq", i), {16'h0, irq_o}, {16'h0, VEC[i][0]});
    end

    step('0, 1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
    step(11'h100, 1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R2 watchdog bit", bus_rdata_o, 17'h15100);
    step('0, 1'b1, 1'b0, 17'h00100, 1'b0, 1'b0, 1'b0, 1'b0);

    step('0, 1'b1, 1'b1, 17'h1FFFF, 1'b0, 1'b0, 1'b0, 1'b0);
    bus_addr_i = 1'b1; #1;
    chk("R5 mask readback", bus_rdata_o, 17'h01FFF);
    bus_addr_i = 1'b0; #1;
    chk("R6 idle irq with full mask", {16'h0, irq_o}, 17'h0);

    step('0, 1'b0, 1'b0, '0, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R7 drop", bus_rdata_o, 17'h14000);
    chk("R6 active-low irq", {16'h0, irq_o}, 17'h1);
    step('0, 1'b1, 1'b0, 17'h01000, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R7 write ignored", bus_rdata_o, 17'h14000);
    step('0, 1'b0, 1'b0, '0, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R7 port init", bus_rdata_o, 17'h15000);
    step('0, 1'b0, 1'b0, '0, 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R7 drop wins", bus_rdata_o, 17'h14000);
    step('0, 1'b0, 1'b0, '0, 1'b0, 1'b1, 1'b0, 1'b0);

    step('0, 1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R8 set", bus_rdata_o, 17'h15800);
    step('0, 1'b1, 1'b0, 17'h00800, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R8 clear blocked", bus_rdata_o, 17'h15800);
    step('0, 1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R8 held after recovery", bus_rdata_o, 17'h15800);
    step('0, 1'b1, 1'b0, 17'h00800, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R8 cleared", bus_rdata_o, 17'h15000);
    chk("R9 revision", {13'h0, bus_rdata_o[16:13]}, 17'h0000A);

    rst_ni = 1'b0; #1;
    chk("R1 async reset", bus_rdata_o, 17'h15000);
    rst_ni = 1'b1;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule